// File: doc/BRIEF.md
# DRAM strobe cycle classifier

This block watches the control strobes of an asynchronous, page-capable DRAM (row strobe, two byte-lane column strobes, write enable and output enable) with a fast system clock. Each strobe is sampled once per clock. From the order in which the strobes change, the block decides what kind of memory cycle took place. A memory controller testbench or an on-chip bus monitor uses it to confirm that a controller produces the cycles it intends, without relying on analog timing.

The two column strobes are merged into one column strobe. This merged strobe is active from the first lane strobe going active until the last lane strobe going inactive. A cycle begins when the row strobe goes active. It ends only when the row strobe and both column strobes have all returned inactive. The block then reports the cycle with a one-clock valid pulse, a 4-bit type code, a 2-bit byte-lane mask and the number of column accesses made inside the row. A sticky flag is raised when the row strobe stays active for fewer samples than a configurable minimum.

States of the classifier: IDLE (all strobes inactive), CAS_ONLY (a column strobe is active and the row strobe is inactive), ROW (row strobe active, no column yet), ACCESS (column accesses within the open row), CBR (a refresh started with the column strobe first), TAIL (the row strobe has closed while the column strobe is still held) and HIDDEN (the row strobe reopened during TAIL). The transitions are:
- IDLE to ROW or CBR when the row strobe goes active, or to CAS_ONLY when only a column strobe does.
- CAS_ONLY to CBR when the row strobe goes active, or back to IDLE (reporting standby) when the column strobe releases.
- ROW to ACCESS on the first column strobe, or to IDLE (reporting a row-only refresh) when the row strobe closes.
- ACCESS to IDLE when all strobes are inactive, or to TAIL when the row strobe closes with a column strobe still held.
- TAIL to HIDDEN when the row strobe reopens, or to IDLE when all strobes are inactive.
- HIDDEN and CBR to IDLE when all strobes are inactive.

Top module: `dram_cycle_classifier`

## Requirements
- R1: A cycle is reported only after the row strobe and both column strobes are all sampled inactive; each report is a single-clock `cyc_valid` pulse, and nothing is reported while any strobe stays active.
- R2: The merged column strobe counts as one falling edge when the two lane strobes go active at staggered times; `cyc_lanes` bit 0 marks the lower lane strobe and bit 1 the upper lane strobe, set for each strobe seen active during the row.
- R3: A column strobe active before the row strobe goes active gives type 6 (refresh with the column strobe first), with lanes 0 and pages 0.
- R4: A row strobe pulse with both column strobes inactive throughout gives type 5 (row-only refresh), with lanes 0 and pages 0.
- R5: One column access with write enable inactive gives type 1 (read), with pages 1.
- R6: Write enable already active when the column strobe goes active gives type 2 (early write).
- R7: Write enable going active after the column strobe gives type 3 (late write) if output enable was not active during that column access. It gives type 8 (read-modify-write) if output enable was active before write enable went active.
- R8: Each further merged column falling edge while the row strobe stays active adds one to `cyc_pages`. Two or more accesses give type 4 (page access). The count saturates at 2^PAGE_W-1.
- R9: A column strobe held through a row strobe inactive gap, followed by the row strobe going active again, gives type 7 (hidden refresh). The lanes and pages reported are those of the preceding access.
- R10: A column strobe pulse with the row strobe inactive throughout gives type 0 (standby), with lanes 0 and pages 0.
- R11: A row strobe active for fewer than MIN_RAS consecutive samples sets `err_short`, which stays set until reset. Exactly MIN_RAS samples does not set it.
- R12: After reset, `cyc_valid` and `err_short` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte-lane column strobe, active low |
| ucas_n | input | 1 | Upper byte-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_valid | output | 1 | One-clock pulse per completed cycle |
| cyc_type | output | 4 | Cycle type code |
| cyc_lanes | output | 2 | Byte lanes touched (bit 0 lower, bit 1 upper) |
| cyc_pages | output | PAGE_W | Column accesses in the row |
| err_short | output | 1 | Sticky too-short row strobe flag |

## Verification
The classifier is driven with directed strobe orderings for each cycle type: column strobe before row strobe, row strobe alone, column strobe alone, write enable before and after the column strobe, with and without output enable, staggered lane strobes and a column strobe held across a row gap. These show whether the state machine separates the orderings that differ only in which edge came first. Randomly mixed lane masks, write modes, page counts and hidden-refresh endings from a fixed seed check that the type, lane and page fields stay independent of one another. Row strobe widths of exactly the minimum and one sample less bound the width check, and a held column strobe after a refresh shows that no report is made early.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [3:0] {
        CK_STANDBY  = 4'd0,
        CK_READ     = 4'd1,
        CK_EARLY_WR = 4'd2,
        CK_LATE_WR  = 4'd3,
        CK_PAGE     = 4'd4,
        CK_RAS_ONLY = 4'd5,
        CK_CBR      = 4'd6,
        CK_HIDDEN   = 4'd7,
        CK_RMW      = 4'd8
    } cyc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CAS_ONLY,
        S_ROW,
        S_ACCESS,
        S_CBR,
        S_TAIL,
        S_HIDDEN
    } cls_state_e;

    // Sampled strobes, active high
    typedef struct packed {
        logic ras;
        logic lcas;
        logic ucas;
        logic we;
        logic oe;
    } strobe_t;

endpackage

// File: rtl/dcc_sampler.sv
module dcc_sampler
    import dcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ras_n,
    input  logic    lcas_n,
    input  logic    ucas_n,
    input  logic    we_n,
    input  logic    oe_n,
    output strobe_t cur,
    output logic    ras_prev,
    output logic    cas_fall
);

    strobe_t smp_q;
    logic    ras_q;
    logic    cas_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
            ras_q <= 1'b0;
            cas_q <= 1'b0;
        end else begin
            smp_q <= '{ras: ~ras_n, lcas: ~lcas_n, ucas: ~ucas_n, we: ~we_n, oe: ~oe_n};
            ras_q <= smp_q.ras;
            cas_q <= smp_q.lcas | smp_q.ucas;
        end
    end

    assign cur      = smp_q;
    assign ras_prev = ras_q;
    // merged strobe: first lane active opens it, last lane inactive closes it
    assign cas_fall = (smp_q.lcas | smp_q.ucas) & ~cas_q;

endmodule

// File: rtl/dcc_ras_width.sv
module dcc_ras_width #(
    parameter int MIN_RAS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_now,
    input  logic ras_prev,
    output logic err_short
);

    localparam int CNT_W = $clog2(MIN_RAS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            err_short <= 1'b0;
        end else begin
            if (ras_now) begin
                if (!ras_prev)
                    cnt_q <= CNT_W'(1);
                else if (cnt_q != CNT_W'(MIN_RAS))
                    cnt_q <= cnt_q + CNT_W'(1);
            end else if (ras_prev && (cnt_q < CNT_W'(MIN_RAS))) begin
                err_short <= 1'b1;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_short |=> err_short); // R11

endmodule

// File: rtl/dcc_cycle_fsm.sv
module dcc_cycle_fsm
    import dcc_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           cur,
    input  logic              cas_fall,
    output logic              cyc_valid,
    output logic [3:0]        cyc_type,
    output logic [1:0]        cyc_lanes,
    output logic [PAGE_W-1:0] cyc_pages
);

    cls_state_e        state_q, state_d;
    cyc_kind_e         kind_q;
    logic [1:0]        lanes_q;
    logic [PAGE_W-1:0] pages_q;
    logic              oe_q;

    logic              cas_a;
    logic              rep;
    cyc_kind_e         rep_type;
    cyc_kind_e         acc_type;
    logic [1:0]        rep_lanes;
    logic [PAGE_W-1:0] rep_pages;

    assign cas_a    = cur.lcas | cur.ucas;
    assign acc_type = (pages_q >= PAGE_W'(2)) ? CK_PAGE : kind_q;

    always_comb begin
        state_d   = state_q;
        rep       = 1'b0;
        rep_type  = CK_STANDBY;
        rep_lanes = '0;
        rep_pages = '0;
        unique case (state_q)
            S_IDLE: begin
                if (cur.ras)
                    state_d = cas_a ? S_CBR : S_ROW;
                else if (cas_a)
                    state_d = S_CAS_ONLY;
            end
            S_CAS_ONLY: begin
                if (cur.ras) begin
                    state_d = S_CBR;
                end else if (!cas_a) begin
                    rep     = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_ROW: begin
                if (cas_a) begin
                    state_d = S_ACCESS;
                end else if (!cur.ras) begin
                    rep      = 1'b1;
                    rep_type = CK_RAS_ONLY;
                    state_d  = S_IDLE;
                end
            end
            S_ACCESS: begin
                if (!cur.ras) begin
                    if (!cas_a) begin
                        rep       = 1'b1;
                        rep_type  = acc_type;
                        rep_lanes = lanes_q;
                        rep_pages = pages_q;
                        state_d   = S_IDLE;
                    end else begin
                        state_d = S_TAIL;
                    end
                end
            end
            S_TAIL: begin
                if (cur.ras && cas_a) begin
                    state_d = S_HIDDEN;
                end else if (!cur.ras && !cas_a) begin
                    rep       = 1'b1;
                    rep_type  = acc_type;
                    rep_lanes = lanes_q;
                    rep_pages = pages_q;
                    state_d   = S_IDLE;
                end
            end
            S_HIDDEN: begin
                if (!cur.ras && !cas_a) begin
                    rep       = 1'b1;
                    rep_type  = CK_HIDDEN;
                    rep_lanes = lanes_q;
                    rep_pages = pages_q;
                    state_d   = S_IDLE;
                end
            end
            S_CBR: begin
                if (!cur.ras && !cas_a) begin
                    rep      = 1'b1;
                    rep_type = CK_CBR;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // per-cycle bookkeeping of the access in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CK_READ;
            lanes_q <= '0;
            pages_q <= '0;
            oe_q    <= 1'b0;
        end else if (state_q == S_IDLE) begin
            kind_q  <= CK_READ;
            lanes_q <= '0;
            pages_q <= '0;
            oe_q    <= 1'b0;
        end else if (state_q == S_ROW && cas_a) begin
            kind_q  <= cur.we ? CK_EARLY_WR : CK_READ;
            lanes_q <= {cur.ucas, cur.lcas};
            pages_q <= PAGE_W'(1);
            oe_q    <= cur.oe;
        end else if (state_q == S_ACCESS) begin
            if (cas_a)
                lanes_q <= lanes_q | {cur.ucas, cur.lcas};
            if (cas_fall && (pages_q != '1))
                pages_q <= pages_q + PAGE_W'(1);
            if (cas_a && cur.oe)
                oe_q <= 1'b1;
            if (cas_a && cur.we && kind_q == CK_READ)
                kind_q <= (oe_q | cur.oe) ? CK_RMW : CK_LATE_WR;
        end
    end

    // registered report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_valid <= 1'b0;
            cyc_type  <= '0;
            cyc_lanes <= '0;
            cyc_pages <= '0;
        end else begin
            cyc_valid <= rep;
            if (rep) begin
                cyc_type  <= rep_type;
                cyc_lanes <= rep_lanes;
                cyc_pages <= rep_pages;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid); // R1

    AST_END_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_valid) |-> $past(!cur.ras && !cas_a)); // R1

    AST_REFRESH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && (cyc_type == CK_RAS_ONLY || cyc_type == CK_CBR || cyc_type == CK_STANDBY)
        |-> (cyc_lanes == 2'b00 && cyc_pages == '0)); // R3

    AST_PAGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cyc_type == CK_PAGE |-> cyc_pages >= PAGE_W'(2)); // R8

    AST_SINGLE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && (cyc_type == CK_READ || cyc_type == CK_EARLY_WR ||
                      cyc_type == CK_LATE_WR || cyc_type == CK_RMW)
        |-> (cyc_pages == PAGE_W'(1) && cyc_lanes != 2'b00)); // R5

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dcc_pkg::*;
#(
    parameter int PAGE_W  = 4,
    parameter int MIN_RAS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic              cyc_valid,
    output logic [3:0]        cyc_type,
    output logic [1:0]        cyc_lanes,
    output logic [PAGE_W-1:0] cyc_pages,
    output logic              err_short
);

    strobe_t cur;
    logic    ras_prev;
    logic    cas_fall;

    dcc_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .lcas_n   (lcas_n),
        .ucas_n   (ucas_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .cur      (cur),
        .ras_prev (ras_prev),
        .cas_fall (cas_fall)
    );

    dcc_cycle_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (cur),
        .cas_fall  (cas_fall),
        .cyc_valid (cyc_valid),
        .cyc_type  (cyc_type),
        .cyc_lanes (cyc_lanes),
        .cyc_pages (cyc_pages)
    );

    dcc_ras_width #(.MIN_RAS(MIN_RAS)) u_width (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_now   (cur.ras),
        .ras_prev  (ras_prev),
        .err_short (err_short)
    );

endmodule

// File: tb/dram_cycle_classifier_tb.sv
module dram_cycle_classifier_tb;

    localparam int PAGE_W  = 4;
    localparam int MIN_RAS = 8;
    localparam int PMAX    = (1 << PAGE_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic              cyc_valid;
    logic [3:0]        cyc_type;
    logic [1:0]        cyc_lanes;
    logic [PAGE_W-1:0] cyc_pages;
    logic              err_short;

    int checks = 0;
    int errors = 0;
    int ev_cnt = 0;
    int ev_type, ev_lanes, ev_pages;

    always #2 clk = ~clk;

    dram_cycle_classifier #(.PAGE_W(PAGE_W), .MIN_RAS(MIN_RAS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
        .cyc_lanes(cyc_lanes), .cyc_pages(cyc_pages), .err_short(err_short)
    );

    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            ev_cnt   = ev_cnt + 1;
            ev_type  = int'(cyc_type);
            ev_lanes = int'(cyc_lanes);
            ev_pages = int'(cyc_pages);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic expect_one(input string req, input int t, input int l, input int p);
        check({req, " report count"}, ev_cnt, 1);
        check({req, " type"}, ev_type, t);
        check({req, " lanes"}, ev_lanes, l);
        check({req, " pages"}, ev_pages, p);
        ev_cnt = 0;
    endtask

    function automatic int exp_type(input int mode, input int npg, input bit hidden);
        if (hidden) return 7;
        if (npg >= 2) return 4;
        case (mode)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_pages(input int npg);
        return (npg > PMAX) ? PMAX : npg;
    endfunction

    // mode: 0 read, 1 early write, 2 late write, 3 read-modify-write
    task automatic run_access(input logic [1:0] lanes, input int mode, input int npg, input bit hidden);
        ras_n = 1'b0;
        step(MIN_RAS);
        for (int p = 0; p < npg; p++) begin
            if (mode == 1) we_n = 1'b0;
            lcas_n = ~lanes[0];
            ucas_n = ~lanes[1];
            step(2);
            if (mode == 2) begin we_n = 1'b0; step(2); we_n = 1'b1; end
            if (mode == 3) begin
                oe_n = 1'b0; step(2); oe_n = 1'b1; step(1);
                we_n = 1'b0; step(2); we_n = 1'b1;
            end
            if (!(hidden && p == npg - 1)) begin
                lcas_n = 1'b1; ucas_n = 1'b1; step(2);
            end
        end
        if (hidden) begin
            ras_n = 1'b1; step(3);
            ras_n = 1'b0; step(MIN_RAS);
            ras_n = 1'b1; step(2);
            lcas_n = 1'b1; ucas_n = 1'b1;
        end else begin
            ras_n = 1'b1;
        end
        we_n = 1'b1;
        step(5);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1: watchdog expired, got 0 expected 1");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        step(3);
        // R12: reset state
        check("R12 valid", int'(cyc_valid), 0);
        check("R12 err", int'(err_short), 0);
        rst_n = 1'b1;
        step(3);
        check("R12 no report", ev_cnt, 0);

        run_access(2'b11, 0, 1, 1'b0); expect_one("R5 word read", 1, 3, 1);
        run_access(2'b01, 0, 1, 1'b0); expect_one("R2 lower byte read", 1, 1, 1);
        run_access(2'b10, 1, 1, 1'b0); expect_one("R6 upper early write", 2, 2, 1);
        run_access(2'b11, 2, 1, 1'b0); expect_one("R7 late write", 3, 3, 1);
        run_access(2'b11, 3, 1, 1'b0); expect_one("R7 read-modify-write", 8, 3, 1);
        run_access(2'b11, 0, 3, 1'b0); expect_one("R8 page read", 4, 3, 3);
        run_access(2'b01, 1, 17, 1'b0); expect_one("R8 page saturate", 4, 1, PMAX);
        run_access(2'b10, 0, 1, 1'b1); expect_one("R9 hidden refresh", 7, 2, 1);

        // R2: staggered lane strobes form one merged access
        ras_n = 1'b0; step(MIN_RAS);
        lcas_n = 1'b0; step(1);
        ucas_n = 1'b0; step(2);
        lcas_n = 1'b1; step(1);
        ucas_n = 1'b1; step(2);
        ras_n = 1'b1; step(5);
        expect_one("R2 staggered strobes", 1, 3, 1);

        // R4: row-only refresh
        ras_n = 1'b0; step(10); ras_n = 1'b1; step(5);
        expect_one("R4 row-only refresh", 5, 0, 0);

        // R3 and R1: column first, then row; column held after row closes
        lcas_n = 1'b0; step(2);
        ras_n = 1'b0; step(10);
        ras_n = 1'b1; step(6);
        check("R1 no report while column held", ev_cnt, 0);
        lcas_n = 1'b1; step(5);
        expect_one("R3 column-first refresh", 6, 0, 0);

        // R10: column pulse with row inactive
        ucas_n = 1'b0; step(3); ucas_n = 1'b1; step(5);
        expect_one("R10 standby", 0, 0, 0);

        // constrained random mix
        for (int i = 0; i < 30; i++) begin
            logic [1:0] ln;
            int md, np;
            bit hd;
            ln = 2'(1 + ($urandom % 3));
            md = int'($urandom % 4);
            np = int'(1 + ($urandom % 5));
            hd = (($urandom % 4) == 0);
            run_access(ln, md, np, hd);
            expect_one("R8 random", exp_type(md, np, hd), int'(ln), exp_pages(np));
        end

        // R11: width boundary
        check("R11 no error so far", int'(err_short), 0);
        ras_n = 1'b0; step(MIN_RAS); ras_n = 1'b1; step(5);
        expect_one("R11 exact minimum", 5, 0, 0);
        check("R11 exact minimum no error", int'(err_short), 0);
        ras_n = 1'b0; step(MIN_RAS - 1); ras_n = 1'b1; step(5);
        expect_one("R11 short cycle", 5, 0, 0);
        check("R11 short sets error", int'(err_short), 1);
        run_access(2'b11, 0, 1, 1'b0); expect_one("R11 after error", 1, 3, 1);
        check("R11 error sticky", int'(err_short), 1);

        finish_run();
    end

endmodule